// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block is the transmit serializer of a UART. It accepts one character at a time over a valid/ready handshake and shifts it out on a single TX line. Each bit lasts a fixed number of pulses of a 16x oversample tick. The frame shape comes from an 8-bit line-control byte. The low two bits set the word length. Further bits set the stop length, turn parity on, pick its sense or force its value, and request a continuous break.

An accepted frame has a low start bit, then the data bits with the least significant bit first. An optional parity bit follows, then a high stop period. The control byte is captured when the character is accepted, so a later change affects only the next frame. A break request waits for the frame in progress to end and then holds the line low until the request is cleared. The baud tick source, the character FIFO and the receiver sit outside this block.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset txLine is high, busy is low and charReady is high (when lineCtrl bit 6 is clear).
- R2: A character is taken on a clock edge where charValid and charReady are both high. charReady is low whenever busy is high. The control byte is captured on that edge, and later changes do not alter the frame in progress.
- R3: lineCtrl[1:0] sets the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The frame opens with one low start bit, and the data follows least significant bit first. Every start, data and parity bit lasts 16 tick pulses.
- R4: With lineCtrl bit 2 clear the stop period is 16 ticks high. With bit 2 set it is 24 ticks for 5-bit words and 32 ticks for any other width.
- R5: lineCtrl bit 3 inserts a parity bit after the data. With bit 5 clear, bit 4 set gives even parity (data plus parity hold an even count of ones) and bit 4 clear gives odd parity.
- R6: With bits 3 and 5 both set, the parity bit equals lineCtrl bit 4, whatever the data. A 1 marks an address character.
- R7: With bit 3 clear there is no parity slot, and bits 4 and 5 have no effect on the line.
- R8: lineCtrl bit 6 set while idle drives txLine low, holds busy high and holds charReady low until the bit is cleared. Setting it during a frame lets that frame finish before the break begins.
- R9: Tick pulses alone advance bit timing. A character that is waiting is accepted on the first edge after the stop period ends, so consecutive frames have no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| lineCtrl | input | 8 | Line-control byte (width, stop, parity, break) |
| charData | input | 8 | Character to transmit |
| charValid | input | 1 | charData holds a character |
| charReady | output | 1 | Block can take a character on this edge |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame or break in progress |

## Verification
Two functions can compete in the same idle cycle: a break request and a waiting character. The bench provokes this by raising lineCtrl bit 6 while a frame is still shifting and keeping charValid high with a second character. At the frame boundary the break must win, and the character must be taken only on the edge after the break is released. A behavioural queue model of the expected line levels and tick counts judges each clock. The model is also compared on every clock while the tick rate changes and frames run back to back.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS      = 16;
  localparam int MAX_BITS = 8;
  localparam int FRAME_W  = MAX_BITS + 3;
  localparam int TICK_W   = $clog2(2 * OVS);
  localparam int LEN_W    = TICK_W + 1;
  localparam int IDX_W    = $clog2(FRAME_W + 1);

  localparam int LC_STOP  = 2;
  localparam int LC_PAREN = 3;
  localparam int LC_PSEL  = 4;
  localparam int LC_FORCE = 5;
  localparam int LC_BRK   = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_BREAK = 2'd2
  } txState_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic breakSet;
    logic breakClr;
    logic active;
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [7:0] lineCtrl,
  input  logic       charValid,
  output logic       charReady,
  output logic       busy,
  output txStrobe_t  strobe
);
  txState_e          state, stateN;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx, lastIdx, lastIdxNew;
  logic [LEN_W-1:0]  stopTicks, stopTicksNew, curLen;
  logic              endOfBit;

  // frame geometry decoded from the live byte, captured on load
  always_comb begin
    lastIdxNew = IDX_W'(1) + IDX_W'(5) + IDX_W'(lineCtrl[1:0]) + IDX_W'(lineCtrl[LC_PAREN]);
    if (!lineCtrl[LC_STOP])       stopTicksNew = LEN_W'(OVS);
    else if (lineCtrl[1:0] == 2'b00) stopTicksNew = LEN_W'(OVS + OVS / 2);
    else                          stopTicksNew = LEN_W'(2 * OVS);
  end

  assign curLen   = (bitIdx == lastIdx) ? stopTicks : LEN_W'(OVS);
  assign endOfBit = ({1'b0, tickCnt} == (curLen - LEN_W'(1)));

  always_comb begin
    stateN    = state;
    strobe    = '0;
    busy      = (state != ST_IDLE);
    charReady = (state == ST_IDLE) && !lineCtrl[LC_BRK];
    strobe.active = busy;
    unique case (state)
      ST_IDLE: begin
        if (lineCtrl[LC_BRK]) begin
          strobe.breakSet = 1'b1;
          stateN          = ST_BREAK;
        end else if (charValid) begin
          strobe.load = 1'b1;
          stateN      = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (tick16 && endOfBit) begin
          if (bitIdx == lastIdx) stateN = ST_IDLE;
          else                   strobe.shift = 1'b1;
        end
      end
      ST_BREAK: begin
        if (!lineCtrl[LC_BRK]) begin
          strobe.breakClr = 1'b1;
          stateN          = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      lastIdx   <= '0;
      stopTicks <= LEN_W'(OVS);
    end else begin
      state <= stateN;
      if (strobe.load) begin
        tickCnt   <= '0;
        bitIdx    <= '0;
        lastIdx   <= lastIdxNew;
        stopTicks <= stopTicksNew;
      end else if (state == ST_FRAME && tick16) begin
        if (endOfBit) begin
          tickCnt <= '0;
          bitIdx  <= bitIdx + IDX_W'(1);
        end else begin
          tickCnt <= tickCnt + TICK_W'(1);
        end
      end
    end
  end

  // R9: bits advance only on tick pulses
  a_r9_shift_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> tick16);
  // R2: no acceptance window while a frame or break runs
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !charReady);
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  strobe,
  input  logic [7:0] lineCtrl,
  input  logic [7:0] charData,
  output logic       txLine
);
  logic [FRAME_W-1:0] shiftReg, frameWord;
  logic               breakHold;
  logic [IDX_W-1:0]   nData;
  logic [7:0]         dataMask;
  logic               parBit;

  assign nData = IDX_W'(5) + IDX_W'(lineCtrl[1:0]);

  always_comb begin
    dataMask = '0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nData)) dataMask[i] = 1'b1;
    if (lineCtrl[LC_FORCE]) parBit = lineCtrl[LC_PSEL];
    else                    parBit = (^(charData & dataMask)) ^ ~lineCtrl[LC_PSEL];
    frameWord    = '1;
    frameWord[0] = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nData)) frameWord[1 + i] = charData[i];
    if (lineCtrl[LC_PAREN]) frameWord[nData + IDX_W'(1)] = parBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '1;
      breakHold <= 1'b0;
    end else begin
      if (strobe.load)       shiftReg <= frameWord;
      else if (strobe.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      if (strobe.breakSet)      breakHold <= 1'b1;
      else if (strobe.breakClr) breakHold <= 1'b0;
    end
  end

  assign txLine = shiftReg[0] & ~breakHold;

  // R1/R9: with nothing in flight the register has drained to ones
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> txLine);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [7:0] lineCtrl,
  input  logic [7:0] charData,
  input  logic       charValid,
  output logic       charReady,
  output logic       txLine,
  output logic       busy
);
  txStrobe_t strobe;

  uart_tx_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .lineCtrl  (lineCtrl),
    .charValid (charValid),
    .charReady (charReady),
    .busy      (busy),
    .strobe    (strobe)
  );

  uart_tx_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lineCtrl (lineCtrl),
    .charData (charData),
    .txLine   (txLine)
  );

  // R2: an accepted character starts with a low start bit
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && charReady) |=> (busy && !txLine));
  // R8: a break request seen while idle pulls the line low
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && lineCtrl[6]) |=> (busy && !txLine));
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] lineCtrl = 8'h03;
  logic [7:0] charData = 8'h00;
  logic       charValid = 1'b0;
  logic       charReady, txLine, busy;

  int errors = 0;
  int checks = 0;
  int tickDiv = 3;
  bit done = 0;
  string curTag = "R1";

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .lineCtrl(lineCtrl),
    .charData(charData), .charValid(charValid), .charReady(charReady),
    .txLine(txLine), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick generator
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      tick16 = ((cnt % tickDiv) == 0);
    end
  end

  // reference model: queue of (level, length-in-ticks)
  int lvQ[$];
  int lnQ[$];
  int mState = 0;  // 0 idle, 1 frame, 2 break
  int curTick = 0;
  bit mTx = 1'b1;

  task automatic buildFrame(input logic [7:0] d, input logic [7:0] lc);
    int n = 5 + int'(lc[1:0]);
    int ones = 0;
    int stopLen;
    lvQ.delete(); lnQ.delete();
    lvQ.push_back(0); lnQ.push_back(16);
    for (int i = 0; i < n; i++) begin
      lvQ.push_back(int'(d[i])); lnQ.push_back(16);
      ones += int'(d[i]);
    end
    if (lc[3]) begin
      int p;
      if (lc[5]) p = int'(lc[4]);
      else if (lc[4]) p = ones % 2;
      else p = 1 - (ones % 2);
      lvQ.push_back(p); lnQ.push_back(16);
    end
    if (!lc[2]) stopLen = 16;
    else if (n == 5) stopLen = 24;
    else stopLen = 32;
    lvQ.push_back(1); lnQ.push_back(stopLen);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTx = 1'b1; curTick = 0;
    end else begin
      case (mState)
        0: if (lineCtrl[6]) begin mState = 2; mTx = 1'b0; end
           else if (charValid) begin
             buildFrame(charData, lineCtrl);
             mState = 1; curTick = 0; mTx = lvQ[0][0];
           end
        1: if (tick16) begin
             curTick++;
             if (curTick == lnQ[0]) begin
               void'(lvQ.pop_front()); void'(lnQ.pop_front());
               curTick = 0;
               if (lvQ.size() == 0) begin mState = 0; mTx = 1'b1; end
               else mTx = lvQ[0][0];
             end
           end
        default: if (!lineCtrl[6]) begin mState = 0; mTx = 1'b1; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(txLine == mTx, {curTag, " txLine"}, int'(txLine), int'(mTx));
      chk(busy == (mState != 0), {curTag, " busy"}, int'(busy), int'(mState != 0));
      chk(charReady == (mState == 0 && !lineCtrl[6]), {curTag, " charReady"},
          int'(charReady), int'(mState == 0 && !lineCtrl[6]));
    end
  end

  task automatic sendChar(input logic [7:0] d, input logic [7:0] lc, input string tag);
    @(posedge clk); #1;
    curTag = tag; lineCtrl = lc; charData = d; charValid = 1'b1;
    do @(negedge clk); while (!charReady);
    @(posedge clk); #1;
    charValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine == 1'b1, "R1 txLine after reset", int'(txLine), 1);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(charReady == 1'b1, "R1 charReady after reset", int'(charReady), 1);

    sendChar(8'hA5, 8'h03, "R3 8-bit"); waitIdle();
    sendChar(8'h16, 8'h00, "R3 5-bit"); waitIdle();
    sendChar(8'h2B, 8'h01, "R3 6-bit"); waitIdle();
    sendChar(8'h5A, 8'h02, "R3 7-bit"); waitIdle();
    sendChar(8'h1D, 8'h04, "R4 5-bit 1.5 stop"); waitIdle();
    sendChar(8'hC3, 8'h07, "R4 8-bit 2 stop"); waitIdle();
    sendChar(8'h2E, 8'h05, "R4 6-bit 2 stop"); waitIdle();
    sendChar(8'h37, 8'h1B, "R5 even parity"); waitIdle();
    sendChar(8'h37, 8'h0B, "R5 odd parity"); waitIdle();
    sendChar(8'h00, 8'h0A, "R5 odd parity 7-bit zero"); waitIdle();
    sendChar(8'h00, 8'h3B, "R6 forced one"); waitIdle();
    sendChar(8'hFF, 8'h2B, "R6 forced zero"); waitIdle();
    sendChar(8'h81, 8'h33, "R7 parity off"); waitIdle();

    // R2 capture: change control during the frame
    sendChar(8'h69, 8'h03, "R2 capture");
    repeat (40) @(posedge clk);
    #1 lineCtrl = 8'h1C;
    waitIdle();

    // R9 back-to-back
    @(posedge clk); #1;
    curTag = "R9 back-to-back"; lineCtrl = 8'h03; charData = 8'h3C; charValid = 1'b1;
    do @(negedge clk); while (!charReady);
    @(posedge clk); #1 charData = 8'hC5;
    do @(negedge clk); while (!charReady);
    chk(txLine == 1'b1, "R9 line high at boundary", int'(txLine), 1);
    @(posedge clk); #1 charValid = 1'b0;
    waitIdle();

    // R8 break while idle, with a character waiting
    @(posedge clk); #1;
    curTag = "R8 break idle"; lineCtrl = 8'h43; charData = 8'h55; charValid = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(txLine == 1'b0, "R8 line low in break", int'(txLine), 0);
    chk(charReady == 1'b0, "R8 no accept in break", int'(charReady), 0);
    @(posedge clk); #1 lineCtrl = 8'h03;
    do @(negedge clk); while (!charReady);
    @(posedge clk); #1 charValid = 1'b0;
    waitIdle();

    // R8 break requested mid-frame while a second character waits
    sendChar(8'h96, 8'h03, "R8 break mid-frame");
    repeat (20) @(posedge clk);
    #1 lineCtrl = 8'h43; charData = 8'h0F; charValid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R8 frame continues", int'(busy), 1);
    do @(negedge clk); while (lvQ.size() != 0 || mState == 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(txLine == 1'b0, "R8 break after frame", int'(txLine), 0);
    @(posedge clk); #1 lineCtrl = 8'h03;
    do @(negedge clk); while (!charReady);
    @(posedge clk); #1 charValid = 1'b0;
    waitIdle();

    // R3/R9 at full tick rate
    tickDiv = 1;
    sendChar(8'hE7, 8'h1F, "R3 fast ticks"); waitIdle();
    sendChar(8'h0B, 8'h0C, "R4 fast 1.5 stop"); waitIdle();

    repeat (5) @(posedge clk);
    finishRun();
  end
endmodule